// File: doc/BRIEF.md
# Optical-Black Clamp Pulse Generator

This block produces one active-low clamp pulse per sensor line. The pulse tells the analog front end when the optical-black pixels are present on the sensor output. The block finds the start of each line as the falling edge of a horizontal strobe and counts clock cycles from that point. The clamp is asserted while the count lies inside a window. The bounds of that window come from a small table.

Three register fields choose the window. A 2-bit pattern code selects a normal, early, late or wide window. A sensor-select bit chooses between two sets of bounds. A wide-clamp enable forces the wide window on lines that a vertical optical-black flag marks. The block captures the fields and the flag on the cycle a line starts, so it ignores changes made partway through a line.

Top module: `obc_pulse_gen`

## Requirements
- R1: Line position is counted in clock edges. The edge that first samples the strobe low after sampling it high is position 0, and each later edge adds one. The output after edge k reflects position k.
- R2: `clamp_n_o` is active low. It is 0 exactly for positions start through stop−1 of the selected window, and 1 at every other position.
- R3: With `sensor_b_i`=0, pattern codes 00 (the default), 01, 10 and 11 give windows 20–44, 14–38, 26–50 and 14–50.
- R4: With `sensor_b_i`=1, the same codes give windows 19–45, 13–39, 25–51 and 13–51.
- R5: If `wide_en_i` and `vob_line_i` are both 1 when a line starts, the selected sensor's wide window (the code-11 bounds) is used and the pattern code is ignored.
- R6: If `wide_en_i` is 1 and `vob_line_i` is 0, the pattern code selects the window as usual.
- R7: The sensor bit, pattern code, wide enable and vertical-OB flag are sampled on the position-0 edge. Changes to them later in the line have no effect until the next line starts.
- R8: The position counter saturates at its maximum value (4095 by default) instead of wrapping, so a long line produces no second pulse.
- R9: Reset drives `clamp_n_o` to 1 and clears the counter. After reset, no pulse appears until a strobe falling edge is seen.
- R10: A rising edge of the strobe, or a strobe held at one level, does not restart the count. Only a high-to-low transition starts a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hstrobe_i | input | 1 | Horizontal strobe; a falling edge starts a line |
| vob_line_i | input | 1 | High on vertical optical-black lines |
| sensor_b_i | input | 1 | 0 selects sensor A bounds, 1 selects sensor B bounds |
| pattern_i | input | 2 | Window pattern code |
| wide_en_i | input | 1 | Wide-clamp enable for vertical optical-black lines |
| clamp_n_o | output | 1 | Registered active-low clamp pulse |

## Verification
The assertions assume that the strobe and the register fields are synchronous to the clock and change only between its rising edges. They also assume that the window bounds fit well below the counter limit. The stimulus follows these assumptions by driving every input on the falling clock edge. It also keeps lines long enough to reach past every window, except for the deliberately long line used to reach saturation. Mid-line changes to the fields, and strobe rises that occur inside a window, are placed at known positions so that the expected clamp edges can be computed in advance.

// File: rtl/obc_pkg.sv
package obc_pkg;

  typedef enum logic [1:0] {
    PAT_NORMAL = 2'b00,
    PAT_EARLY  = 2'b01,
    PAT_LATE   = 2'b10,
    PAT_WIDE   = 2'b11
  } obc_pat_e;

  typedef struct packed {
    logic     sensor_b;
    logic     wide_en;
    logic     vob_line;
    obc_pat_e pat;
  } obc_cfg_t;

  // Leading bound of a window for a given pattern code.
  function automatic int obc_start(input int base, input int shift, input int pat);
    case (pat)
      1:       return base - shift;
      2:       return base + shift;
      3:       return base - shift;
      default: return base;
    endcase
  endfunction

  // Trailing bound (first inactive position) for a given pattern code.
  function automatic int obc_stop(input int base, input int shift, input int pat);
    case (pat)
      1:       return base - shift;
      2:       return base + shift;
      3:       return base + shift;
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/obc_line_timer.sv
module obc_line_timer
  import obc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_i,
  input  obc_cfg_t         cfg_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             valid_next_o,
  output logic             valid_o,
  output obc_cfg_t         cfg_next_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hs_q;
  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;
  obc_cfg_t         cfg_q;
  logic             line_fall;

  assign line_fall = hs_q & ~hs_i;

  always_comb begin
    if (line_fall)
      cnt_next_o = '0;
    else if (!valid_q || cnt_q == CNT_MAX)
      cnt_next_o = cnt_q;
    else
      cnt_next_o = cnt_q + 1'b1;
    valid_next_o = valid_q | line_fall;
    cfg_next_o   = line_fall ? cfg_i : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q    <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else begin
      hs_q    <= hs_i;
      valid_q <= valid_next_o;
      cnt_q   <= cnt_next_o;
      cfg_q   <= cfg_next_o;
    end
  end

  assign valid_o = valid_q;

  p_cnt_restart_r1: assert property (@(posedge clk) disable iff (rst)
    line_fall |=> (cnt_q == '0) && valid_q);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !line_fall && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !line_fall) |=> cnt_q == CNT_MAX);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !line_fall |=> $stable(cfg_q));

endmodule

// File: rtl/obc_window_lut.sv
module obc_window_lut
  import obc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int A_START = 20,
  parameter int A_STOP  = 44,
  parameter int B_START = 19,
  parameter int B_STOP  = 45,
  parameter int SHIFT   = 6
) (
  input  obc_cfg_t         cfg_i,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] stop_o
);

  localparam int N_SENSOR = 2;
  localparam int N_PAT    = 4;

  logic [CNT_W-1:0] tab_start [N_SENSOR][N_PAT];
  logic [CNT_W-1:0] tab_stop  [N_SENSOR][N_PAT];
  logic [1:0]       eff_pat;

  for (genvar s = 0; s < N_SENSOR; s++) begin : g_sensor
    localparam int BS = (s == 0) ? A_START : B_START;
    localparam int BE = (s == 0) ? A_STOP  : B_STOP;
    for (genvar c = 0; c < N_PAT; c++) begin : g_pat
      assign tab_start[s][c] = CNT_W'(obc_start(BS, SHIFT, c));
      assign tab_stop[s][c]  = CNT_W'(obc_stop(BE, SHIFT, c));
    end
  end

  assign eff_pat = (cfg_i.wide_en && cfg_i.vob_line) ? 2'(PAT_WIDE) : 2'(cfg_i.pat);
  assign start_o = tab_start[cfg_i.sensor_b][eff_pat];
  assign stop_o  = tab_stop[cfg_i.sensor_b][eff_pat];

endmodule

// File: rtl/obc_pulse_gen.sv
module obc_pulse_gen
  import obc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int A_START = 20,
  parameter int A_STOP  = 44,
  parameter int B_START = 19,
  parameter int B_STOP  = 45,
  parameter int SHIFT   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hstrobe_i,
  input  logic       vob_line_i,
  input  logic       sensor_b_i,
  input  logic [1:0] pattern_i,
  input  logic       wide_en_i,
  output logic       clamp_n_o
);

  obc_cfg_t         cfg_in;
  obc_cfg_t         cfg_next;
  logic [CNT_W-1:0] cnt_next;
  logic             valid_next;
  logic             line_valid;
  logic [CNT_W-1:0] win_start;
  logic [CNT_W-1:0] win_stop;
  logic             in_window;

  assign cfg_in.sensor_b = sensor_b_i;
  assign cfg_in.wide_en  = wide_en_i;
  assign cfg_in.vob_line = vob_line_i;
  assign cfg_in.pat      = obc_pat_e'(pattern_i);

  obc_line_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .hs_i         (hstrobe_i),
    .cfg_i        (cfg_in),
    .cnt_next_o   (cnt_next),
    .valid_next_o (valid_next),
    .valid_o      (line_valid),
    .cfg_next_o   (cfg_next)
  );

  obc_window_lut #(
    .CNT_W(CNT_W), .A_START(A_START), .A_STOP(A_STOP),
    .B_START(B_START), .B_STOP(B_STOP), .SHIFT(SHIFT)
  ) u_lut (
    .cfg_i   (cfg_next),
    .start_o (win_start),
    .stop_o  (win_stop)
  );

  // Compare against the next count so the registered output lines up with it.
  assign in_window = valid_next && (cnt_next >= win_start) && (cnt_next < win_stop);

  always_ff @(posedge clk) begin
    if (rst) clamp_n_o <= 1'b1;
    else     clamp_n_o <= ~in_window;
  end

  p_idle_before_line_r9: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> clamp_n_o);

endmodule

// File: tb/test_obc_pulse_gen.sv
module test_obc_pulse_gen;

  localparam int CNT_MAX = 4095;

  logic       clk = 1'b0;
  logic       rst;
  logic       hs;
  logic       vob;
  logic       sens;
  logic [1:0] pat;
  logic       wide;
  logic       clamp_n;

  always #10 clk = ~clk;

  obc_pulse_gen i_obc_pulse_gen (
    .clk        (clk),
    .rst        (rst),
    .hstrobe_i  (hs),
    .vob_line_i (vob),
    .sensor_b_i (sens),
    .pattern_i  (pat),
    .wide_en_i  (wide),
    .clamp_n_o  (clamp_n)
  );

  bit    exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  // Reference model state, built from the requirements.
  bit       m_prev = 0;
  bit       m_valid = 0;
  int       m_cnt = 0;
  bit       m_sens = 0;
  bit [1:0] m_pat = 0;
  bit       m_wide = 0;
  bit       m_vob = 0;

  function automatic void win_bounds(input bit sb, input bit [1:0] p, output int s, output int e);
    if (!sb) begin
      case (p)
        2'b00: begin s = 20; e = 44; end
        2'b01: begin s = 14; e = 38; end
        2'b10: begin s = 26; e = 50; end
        default: begin s = 14; e = 50; end
      endcase
    end else begin
      case (p)
        2'b00: begin s = 19; e = 45; end
        2'b01: begin s = 13; e = 39; end
        2'b10: begin s = 25; e = 51; end
        default: begin s = 13; e = 51; end
      endcase
    end
  endfunction

  // Driver: inputs are already set; predict the output after the next rising edge.
  task automatic tick(input string tag);
    int s, e;
    bit expv;
    if (rst) begin
      m_prev = 0; m_valid = 0; m_cnt = 0;
      m_sens = 0; m_pat = 0; m_wide = 0; m_vob = 0;
      expv = 1;
    end else begin
      if (m_prev && !hs) begin
        m_cnt = 0; m_valid = 1;
        m_sens = sens; m_pat = pat; m_wide = wide; m_vob = vob;
      end else if (m_valid && m_cnt < CNT_MAX) begin
        m_cnt++;
      end
      m_prev = hs;
      win_bounds(m_sens, (m_wide && m_vob) ? 2'b11 : m_pat, s, e);
      expv = !(m_valid && m_cnt >= s && m_cnt < e);
    end
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic line(input int len, input string tag);
    hs = 1'b1;
    tick(tag);
    hs = 1'b0;
    for (int i = 0; i < len - 1; i++) tick(tag);
  endtask

  // Monitor: compares one predicted value per cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (clamp_n !== e) begin
          errors++;
          $display("FAIL %s: clamp_n=%b expected %b at %0t", t, clamp_n, e, $time);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hs = 1'b0; vob = 1'b0; sens = 1'b0; pat = 2'b00; wide = 1'b0;
    @(negedge clk);
    // R9: reset state, then no pulse before the first strobe fall
    for (int i = 0; i < 4; i++) tick("R9 reset");
    rst = 1'b0;
    for (int i = 0; i < 60; i++) tick("R9 idle before line");

    // R1/R2/R3: sensor A, every code
    for (int c = 0; c < 4; c++) begin
      pat = 2'(c);
      line(70, "R3 sensor A table");
    end
    // R1/R2/R4: sensor B, every code
    sens = 1'b1;
    for (int c = 0; c < 4; c++) begin
      pat = 2'(c);
      line(70, "R4 sensor B table");
    end
    // R5: wide override on vertical OB lines, both sensors
    wide = 1'b1; vob = 1'b1; pat = 2'b01;
    line(70, "R5 wide override B");
    sens = 1'b0; pat = 2'b10;
    line(70, "R5 wide override A");
    // R6: wide enable without OB line keeps the pattern code
    vob = 1'b0;
    line(70, "R6 wide without vob");
    wide = 1'b0; pat = 2'b00;

    // R7: mid-line field changes are ignored until the next line
    hs = 1'b1; tick("R7 mid-line change");
    hs = 1'b0;
    for (int i = 0; i < 10; i++) tick("R7 mid-line change");
    pat = 2'b10; sens = 1'b1; wide = 1'b1; vob = 1'b1;
    for (int i = 0; i < 60; i++) tick("R7 mid-line change");
    line(70, "R7 next line uses new fields");
    pat = 2'b00; sens = 1'b0; wide = 1'b0; vob = 1'b0;

    // R10: strobe rises inside the window without restarting
    hs = 1'b1; tick("R10 rise ignored");
    hs = 1'b0;
    for (int i = 0; i < 25; i++) tick("R10 rise ignored");
    hs = 1'b1;
    for (int i = 0; i < 10; i++) tick("R10 rise ignored");
    hs = 1'b0;
    for (int i = 0; i < 60; i++) tick("R10 fall restarts");

    // R8: long line reaches saturation without a second pulse
    line(4300, "R8 saturation");
    line(60, "R8 restart after saturation");

    // R9: reset inside the window, then no pulse until a fall
    hs = 1'b1; tick("R9 reset mid-line");
    hs = 1'b0;
    for (int i = 0; i < 25; i++) tick("R9 reset mid-line");
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick("R9 reset mid-line");
    rst = 1'b0;
    for (int i = 0; i < 60; i++) tick("R9 no pulse after reset");
    line(60, "R9 first line after reset");

    @(posedge clk); #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule